// File: doc/BRIEF.md
# Alternate Bus Master Requester

This block is the arbitration front end of a device that borrows a shared bus from a default master. It uses three handshake wires. The local side holds `need_bus` high when it has work. The block then lowers the active-low bus request and waits for the active-low grant. The grant and the two bus-activity lines (address strobe and data acknowledge) come from another clock domain, so each passes through a flop synchronizer of `SYNC_STAGES` stages before the state machine uses it.

A grant alone does not hand over the bus. The block first waits until the synchronized address strobe and data acknowledge are both idle, which means any cycle the default master started has ended. Only then does it assert grant-acknowledge. Bus request stays asserted for the first cycle of acknowledge and is dropped in the next cycle. That cycle is also when `own_start` pulses, telling the local transfer engine it may drive the bus. When the engine raises `xfer_done`, grant-acknowledge is released. The block then rests for `REL_GAP` cycles before it may request again.

The state machine has six states:
- IDLE: moves to REQUEST when `need_bus` is high.
- REQUEST: moves to WAIT_CYCLE_END when the grant is seen.
- WAIT_CYCLE_END: returns to REQUEST if the grant goes away, and moves to ACK once the bus is idle.
- ACK: moves to OWN unconditionally.
- OWN: moves to RELEASE on `xfer_done`.
- RELEASE: returns to IDLE after `REL_GAP` cycles.

Top module: `alt_master_requester`

## Requirements
- R1: While `rst_n` is low, `bus_req_n` and `grant_ack_n` are 1 and `own_start` is 0.
- R2: With `need_bus` high in IDLE, `bus_req_n` goes to 0 and stays 0 until after `grant_ack_n` has gone to 0.
- R3: `grant_ack_n` goes to 0 only after a cycle in which the synchronized grant is 0 and the synchronized address strobe and data acknowledge are both 1. While either activity line is 0, grant-acknowledge stays 1.
- R4: If the synchronized grant returns to 1 before acknowledge, the block goes back to REQUEST with `bus_req_n` still 0. Bus activity ending later does not produce an acknowledge until the grant is seen again.
- R5: In the first cycle with `grant_ack_n` at 0, `bus_req_n` is still 0. In the following cycle `bus_req_n` is 1 and `grant_ack_n` stays 0.
- R6: `own_start` is a one-cycle pulse, high only in the first cycle in which `grant_ack_n` is 0 and `bus_req_n` is 1.
- R7: `xfer_done` is ignored outside OWN. In OWN, `xfer_done` high at a clock edge makes `grant_ack_n` 1 after that edge.
- R8: With `need_bus` held high, `bus_req_n` falls exactly `REL_GAP`+1 clock edges after the edge at which `grant_ack_n` rises.
- R9: On an idle bus, `grant_ack_n` falls at the `SYNC_STAGES`+2-th rising edge after `bus_grant_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| need_bus | input | 1 | Local side wants the bus (level) |
| xfer_done | input | 1 | Local transfer engine finished; release the bus |
| bus_grant_n | input | 1 | Active-low grant from the default master (asynchronous) |
| addr_strobe_n | input | 1 | Active-low address strobe of the shared bus (asynchronous) |
| data_ack_n | input | 1 | Active-low data acknowledge of the shared bus (asynchronous) |
| bus_req_n | output | 1 | Active-low bus request |
| grant_ack_n | output | 1 | Active-low grant-acknowledge (bus mastership) |
| own_start | output | 1 | One-cycle pulse: bus now owned by the local engine |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `REL_GAP` = 3, both above their defaults. This means the grant-to-acknowledge latency of R9 and the release gap of R8 are measured against a deeper synchronizer and a multi-cycle rest count, not a degenerate one. The longer synchronizer also widens the window in which a grant can be withdrawn during WAIT_CYCLE_END, which is the path back to REQUEST that R4 exercises.

// File: rtl/amr_pkg.sv
package amr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_CYCLE_END,
        ST_ACK,
        ST_OWN,
        ST_RELEASE
    } amr_state_t;
endpackage

// File: rtl/amr_sync.sv
module amr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    // all synchronized lines are active-low, so reset to the idle value 1
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/amr_fsm.sv
module amr_fsm
    import amr_pkg::*;
#(
    parameter int REL_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_bus,
    input  logic xfer_done,
    input  logic grant_seen,
    input  logic strobe_idle,
    input  logic ack_idle,
    output logic bus_req_n,
    output logic grant_ack_n,
    output logic own_start
);
    localparam int CW = (REL_GAP < 2) ? 1 : $clog2(REL_GAP + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(REL_GAP - 1);

    amr_state_t state, state_nx;
    logic [CW-1:0] gap_cnt;

    // state register and rest counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            state   <= state_nx;
            gap_cnt <= (state == ST_RELEASE) ? gap_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:           if (need_bus) state_nx = ST_REQUEST;
            ST_REQUEST:        if (grant_seen) state_nx = ST_WAIT_CYCLE_END;
            ST_WAIT_CYCLE_END: begin
                if (!grant_seen)                  state_nx = ST_REQUEST;
                else if (strobe_idle && ack_idle) state_nx = ST_ACK;
            end
            ST_ACK:            state_nx = ST_OWN;
            ST_OWN:            if (xfer_done) state_nx = ST_RELEASE;
            ST_RELEASE:        if (gap_cnt == GAP_LAST) state_nx = ST_IDLE;
            default:           state_nx = ST_IDLE;
        endcase
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req_n   <= 1'b1;
            grant_ack_n <= 1'b1;
            own_start   <= 1'b0;
        end else begin
            bus_req_n   <= !(state_nx == ST_REQUEST || state_nx == ST_WAIT_CYCLE_END
                             || state_nx == ST_ACK);
            grant_ack_n <= !(state_nx == ST_ACK || state_nx == ST_OWN);
            own_start   <= (state == ST_ACK) && (state_nx == ST_OWN);
        end
    end
endmodule

// File: rtl/alt_master_requester.sv
module alt_master_requester #(
    parameter int SYNC_STAGES = 2,
    parameter int REL_GAP     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_bus,
    input  logic xfer_done,
    input  logic bus_grant_n,
    input  logic addr_strobe_n,
    input  logic data_ack_n,
    output logic bus_req_n,
    output logic grant_ack_n,
    output logic own_start
);
    localparam int NSYNC = 3;

    logic grant_n_s, strobe_n_s, dack_n_s;

    amr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_grant_n, addr_strobe_n, data_ack_n}),
        .sync_out ({grant_n_s, strobe_n_s, dack_n_s})
    );

    amr_fsm #(.REL_GAP(REL_GAP)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .need_bus    (need_bus),
        .xfer_done   (xfer_done),
        .grant_seen  (!grant_n_s),
        .strobe_idle (strobe_n_s),
        .ack_idle    (dack_n_s),
        .bus_req_n   (bus_req_n),
        .grant_ack_n (grant_ack_n),
        .own_start   (own_start)
    );
endmodule

// File: rtl/alt_master_requester_chk.sv
module alt_master_requester_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_done,
    input logic grant_n_s,
    input logic strobe_n_s,
    input logic dack_n_s,
    input logic bus_req_n,
    input logic grant_ack_n,
    input logic own_start
);
    assert_ack_on_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_ack_n) |-> $past(!grant_n_s && strobe_n_s && dack_n_s));

    assert_req_held_into_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_ack_n) |-> !bus_req_n);

    assert_req_drops_under_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_n) |-> !grant_ack_n);

    assert_own_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        own_start |=> !own_start);

    assert_own_pulse_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        own_start |-> (bus_req_n && !grant_ack_n));

    assert_release_by_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_ack_n) |-> $past(xfer_done));
endmodule

bind alt_master_requester alt_master_requester_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_done   (xfer_done),
    .grant_n_s   (grant_n_s),
    .strobe_n_s  (strobe_n_s),
    .dack_n_s    (dack_n_s),
    .bus_req_n   (bus_req_n),
    .grant_ack_n (grant_ack_n),
    .own_start   (own_start)
);

// File: tb/alt_master_requester_test.sv
module alt_master_requester_test;
    localparam int SYNC_STAGES = 3;
    localparam int REL_GAP     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic need_bus = 1'b0, xfer_done = 1'b0;
    logic bus_grant_n = 1'b1, addr_strobe_n = 1'b1, data_ack_n = 1'b1;
    logic bus_req_n, grant_ack_n, own_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [2:0] exp_q[$];
    logic [2:0] prev_obs = 3'b110;

    always #2 clk = ~clk;

    alt_master_requester #(.SYNC_STAGES(SYNC_STAGES), .REL_GAP(REL_GAP)) uut (
        .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .xfer_done(xfer_done),
        .bus_grant_n(bus_grant_n), .addr_strobe_n(addr_strobe_n), .data_ack_n(data_ack_n),
        .bus_req_n(bus_req_n), .grant_ack_n(grant_ack_n), .own_start(own_start)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver side: expected output tuple {bus_req_n, grant_ack_n, own_start}
    task automatic expect_ev(input logic [2:0] t);
        exp_q.push_back(t);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        cycles(1);
        xfer_done = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // monitor: every change of the output tuple is popped and compared
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] cur;
            cur = {bus_req_n, grant_ack_n, own_start};
            if (cur != prev_obs) begin
                if (exp_q.size() == 0) begin
                    check("R2 R5 R6 sequence (unexpected change)", int'(cur), int'(prev_obs));
                end else begin
                    check("R2 R5 R6 sequence", int'(cur), int'(exp_q.pop_front()));
                end
                prev_obs = cur;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        int n;
        // R1: reset values
        cycles(3);
        check("R1 bus_req_n", bus_req_n, 1);
        check("R1 grant_ack_n", grant_ack_n, 1);
        check("R1 own_start", own_start, 0);
        rst_n = 1'b1;
        cycles(2);

        // R2 R9 R5 R6: normal hand-over on an idle bus
        expect_ev(3'b010); expect_ev(3'b000); expect_ev(3'b101); expect_ev(3'b100);
        need_bus = 1'b1;
        cycles(5);
        check("R2 request asserted", bus_req_n, 0);
        bus_grant_n = 1'b0;
        n = 0;
        while (grant_ack_n && n < 50) begin
            @(posedge clk); #1;
            n++;
        end
        check("R9 grant to acknowledge latency", n, SYNC_STAGES + 2);
        check("R5 request still held in first ack cycle", bus_req_n, 0);
        cycles(4);
        bus_grant_n = 1'b1;
        check("R5 request dropped while owning", bus_req_n, 1);
        check("R6 pulse gone", own_start, 0);

        // R7 R8: release with need_bus still high, measure rest gap
        expect_ev(3'b110); expect_ev(3'b010);
        xfer_done = 1'b1;
        @(posedge clk); #1;
        xfer_done = 1'b0;
        check("R7 release after done", grant_ack_n, 1);
        n = 0;
        while (bus_req_n && n < 50) begin
            @(posedge clk); #1;
            n++;
        end
        check("R8 rest gap before new request", n, REL_GAP + 1);
        @(negedge clk);

        // R3: grant while address strobe busy, then while data ack busy
        expect_ev(3'b000); expect_ev(3'b101); expect_ev(3'b100);
        addr_strobe_n = 1'b0;
        bus_grant_n = 1'b0;
        cycles(12);
        check("R3 no ack while strobe busy", grant_ack_n, 1);
        pulse_done();
        cycles(2);
        check("R7 done ignored while requesting", bus_req_n, 0);
        addr_strobe_n = 1'b1;
        data_ack_n = 1'b0;
        cycles(12);
        check("R3 no ack while data ack busy", grant_ack_n, 1);
        data_ack_n = 1'b1;
        cycles(12);
        check("R3 ack once bus idle", grant_ack_n, 0);
        check("R5 request negated in ownership", bus_req_n, 1);
        need_bus = 1'b0;
        bus_grant_n = 1'b1;
        expect_ev(3'b110);
        pulse_done();
        cycles(REL_GAP + 5);

        // R4: grant withdrawn during wait for cycle end
        expect_ev(3'b010);
        need_bus = 1'b1;
        addr_strobe_n = 1'b0;
        bus_grant_n = 1'b0;
        cycles(10);
        bus_grant_n = 1'b1;
        cycles(10);
        addr_strobe_n = 1'b1;
        cycles(10);
        check("R4 request kept after grant loss", bus_req_n, 0);
        check("R4 no ack without grant", grant_ack_n, 1);
        expect_ev(3'b000); expect_ev(3'b101); expect_ev(3'b100);
        bus_grant_n = 1'b0;
        cycles(12);
        check("R4 ack after grant returns", grant_ack_n, 0);
        need_bus = 1'b0;
        bus_grant_n = 1'b1;
        expect_ev(3'b110);
        pulse_done();
        cycles(REL_GAP + 5);

        // R7: done in IDLE has no effect
        pulse_done();
        cycles(5);
        check("R7 done ignored in idle (req)", bus_req_n, 1);
        check("R7 done ignored in idle (ack)", grant_ack_n, 1);
        check("R6 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        summary();
    end
endmodule